// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Number-Addressed Enable and Mask

This block gathers a parameterised number of level-sensitive interrupt lines and presents them to one processor. Each line has two gates: a global enable and a per-processor mask. A line is pending when its input is high, its enable is set and its mask is open. The processor's interrupt output is high while at least one line is pending.

Software never writes bitmaps. It writes the number of a single line to one of four command offsets, which open or close that line's enable or mask. To find work, software reads the acknowledge offset. This returns the lowest pending line number in the low ten bits. If nothing is pending it returns 1023. The read changes no state, so a line stays pending until its input drops. Software services lines and reads acknowledge again until it sees 1023.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every line is disabled and masked. With all inputs high, `irq` is low and an acknowledge read returns 1023.
- R2: A write to offset 0xA30 whose data equals a line number sets that line's enable. No other line changes.
- R3: A write to offset 0xA34 whose data equals a line number clears that line's enable.
- R4: A write to offset 0xBC whose data equals a line number opens that line's mask (unmasks it).
- R5: A write to offset 0xB8 whose data equals a line number closes that line's mask.
- R6: A line qualifies when its input is high, it is enabled and it is unmasked. `irq` is the OR of all qualifying lines. `irq` follows the inputs in the same cycle, and follows a command write from the first clock edge after the write.
- R7: A read strobe at offset 0xB4 loads `rd_data` on that clock edge. `rd_data` then holds the lowest qualifying line number in bits 9:0 and zeros in bits 31:10.
- R8: When no line qualifies, the acknowledge read returns 1023.
- R9: A command write is ignored when its full 32-bit data is at or above `NUM_SRC`. The test value 0x101 is ignored even though its low bits name a valid line.
- R10: An acknowledge read has no side effect. A repeated read returns the same number, and `irq` stays high, for as long as the inputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NUM_SRC | Level-sensitive interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write offset |
| wr_data | input | DW | Write data: the line number |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Read offset |
| rd_data | output | DW | Read data. It is loaded on the edge that samples `rd_en` and held until the next read. |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A command write takes effect at the clock edge that samples it. The bench therefore checks `irq` one nanosecond after changing `src_in` at a falling edge, because the output path is combinational. An acknowledge result appears on the rising edge that samples the read strobe. The bench sets the strobe at a falling edge and reads `rd_data` at the next falling edge. The sweep covers every input pattern of an eight-line configuration under several enable and mask settings. It compares each result against the lowest set bit of the expected AND, or against 1023.

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int          NUM_SRC    = 64,
  parameter int          AW         = 12,
  parameter int          DW         = 32,
  parameter logic [11:0] OFS_ACK    = 12'hB4,
  parameter logic [11:0] OFS_MASK   = 12'hB8,
  parameter logic [11:0] OFS_UNMASK = 12'hBC,
  parameter logic [11:0] OFS_ENA    = 12'hA30,
  parameter logic [11:0] OFS_DIS    = 12'hA34
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic               irq
);
  localparam int         IDW  = 10;
  localparam logic [9:0] SPUR = 10'd1023;

  logic [NUM_SRC-1:0] en_q, unm_q, hit, pend;
  logic [IDW-1:0]     id;

  assign pend = src_in & en_q & unm_q;
  assign irq  = |pend;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit[i] = (wr_data == DW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      unm_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(OFS_ENA))    en_q  <= en_q | hit;
      if (wr_addr == AW'(OFS_DIS))    en_q  <= en_q & ~hit;
      if (wr_addr == AW'(OFS_UNMASK)) unm_q <= unm_q | hit;
      if (wr_addr == AW'(OFS_MASK))   unm_q <= unm_q & ~hit;
    end
  end

  always_comb begin
    id = SPUR;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend[i]) id = IDW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= (rd_addr == AW'(OFS_ACK)) ? DW'(id) : '0;
  end
endmodule

module lvl_irq_ctrl_chk #(
  parameter int          NUM_SRC = 64,
  parameter int          AW      = 12,
  parameter int          DW      = 32,
  parameter logic [11:0] OFS_ACK = 12'hB4,
  parameter logic [11:0] OFS_ENA = 12'hA30
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_in,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [DW-1:0]      wr_data,
  input logic               rd_en,
  input logic [AW-1:0]      rd_addr,
  input logic [DW-1:0]      rd_data,
  input logic               irq,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] unm_q
);
  logic ack_rd;
  assign ack_rd = rd_en && (rd_addr == AW'(OFS_ACK));

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq); // R1
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(OFS_ENA) && wr_data == '0) |=> en_q[0]); // R2
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    (src_in == '0) |-> !irq); // R6
  AST_ACK_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && irq) |=> (rd_data < DW'(NUM_SRC))); // R7
  AST_ACK_SPUR: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !irq) |=> (rd_data == DW'(1023))); // R8
  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data >= DW'(NUM_SRC)) |=> ($stable(en_q) && $stable(unm_q))); // R9
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .AW(AW), .DW(DW), .OFS_ACK(OFS_ACK), .OFS_ENA(OFS_ENA)
) u_chk (
  .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .irq(irq), .en_q(en_q), .unm_q(unm_q)
);

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  localparam int N = 8;
  localparam logic [11:0] A_ACK = 12'hB4, A_MASK = 12'hB8, A_UNM = 12'hBC,
                          A_ENA = 12'hA30, A_DIS = 12'hA34;

  logic clk = 0, rst = 1;
  logic [N-1:0] src_in = '0;
  logic wr_en = 0, rd_en = 0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lvl_irq_ctrl #(.NUM_SRC(N)) u_lvl_irq_ctrl (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ack(output int v);
    @(negedge clk); rd_en = 1; rd_addr = A_ACK;
    @(negedge clk); rd_en = 0; v = int'(rd_data);
  endtask

  task automatic set_state(logic [N-1:0] e, logic [N-1:0] u);
    for (int i = 0; i < N; i++) begin
      wr(e[i] ? A_ENA : A_DIS, 32'(i));
      wr(u[i] ? A_UNM : A_MASK, 32'(i));
    end
  endtask

  function automatic int low_id(logic [N-1:0] q);
    for (int i = 0; i < N; i++) if (q[i]) return i;
    return 1023;
  endfunction

  task automatic probe(string req, logic [N-1:0] s, logic [N-1:0] e, logic [N-1:0] u);
    int v;
    @(negedge clk); src_in = s; #1;
    chk(req, int'(irq), int'(|(s & e & u)));
    ack(v);
    chk(req, v, low_id(s & e & u));
  endtask

  initial begin
    int v, v2;
    logic [N-1:0] es [4] = '{8'hFF, 8'hAA, 8'hFF, 8'h5C};
    logic [N-1:0] us [4] = '{8'hFF, 8'hFF, 8'h0F, 8'h3B};
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset leaves everything closed
    probe("R1", 8'hFF, 8'h00, 8'h00);
    // R2 R4: open line 3 only
    wr(A_ENA, 3); wr(A_UNM, 3);
    probe("R2 R4", 8'h08, 8'h08, 8'h08);
    probe("R6", 8'hF7, 8'h08, 8'h08);
    // R3: disable line 3
    wr(A_DIS, 3);
    probe("R3", 8'h08, 8'h00, 8'h08);
    // R5: re-enable then mask line 3
    wr(A_ENA, 3); wr(A_MASK, 3);
    probe("R5", 8'h08, 8'h08, 8'h00);
    // R9: out-of-range data ignored
    set_state(8'h00, 8'hFF);
    wr(A_ENA, 8); wr(A_ENA, 32'h101); wr(A_ENA, 1023);
    probe("R9", 8'hFF, 8'h00, 8'hFF);
    set_state(8'hFF, 8'h00);
    wr(A_UNM, 32'h101); wr(A_UNM, 32'hFFFF_FFFF);
    probe("R9", 8'hFF, 8'hFF, 8'h00);
    // R6 R7 R8: exhaustive input sweep under several gate settings
    for (int k = 0; k < 4; k++) begin
      set_state(es[k], us[k]);
      for (int s = 0; s < 256; s++) probe("R7 R8", N'(s), es[k], us[k]);
    end
    // R10: repeated acknowledge reads have no side effect
    set_state(8'hFF, 8'hFF);
    @(negedge clk); src_in = 8'h24;
    ack(v); ack(v2);
    chk("R10", v, 2);
    chk("R10", v2, 2);
    #1 chk("R10", int'(irq), 1);
    @(negedge clk); src_in = 8'h20;
    ack(v);
    chk("R10", v, 5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule